// File: doc/BRIEF.md
# Return Address Stack

This block holds the return addresses of a small microcontroller sequencer. It has 16 entries of 14 bits. A subroutine call pushes the current program counter plus one. An interrupt entry pushes the address at which the interrupted code must resume. A return pops an entry back toward the program counter. The stack pointer is 4 bits wide, counts downward and starts at 15, so the first push lands in entry 15. A push writes the entry the pointer selects and then decrements the pointer. A return increments the pointer. The entry above the pointer (pointer plus one, modulo 16) is always driven combinationally on `ret_pc`, so the sequencer takes it in the same cycle that it raises `ret_req`. Plain return, return-and-skip and return-from-interrupt all use this single pop path.

Software reaches the pointer and every entry through a register-style port with a 5-bit index and combinational read data. Only 13 address bits are meaningful, so bit 13 of an entry is cleared on every write path.

Each cycle the controller picks exactly one operation, in this order of priority:
- `OP_PUSH_INT`, interrupt push
- `OP_PUSH_CALL`, call push
- `OP_POP`, return
- `OP_WR_ENTRY`, port write of an entry
- `OP_WR_PTR`, port write of the pointer
- `OP_IDLE`

The operation decides the pointer transition:
- decrement on `OP_PUSH_INT` and `OP_PUSH_CALL`
- increment on `OP_POP`
- load on `OP_WR_PTR`
- hold on `OP_WR_ENTRY` and `OP_IDLE`

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the pointer reads 15 and every entry reads 0.
- R2: When `call_req` is high (and `int_req` low), entry[pointer] takes `pc_in + 1` modulo 2^14 with bit 13 cleared, and the pointer decrements by one.
- R3: When `int_req` is high, entry[pointer] takes `int_addr` with bit 13 cleared, and the pointer decrements by one.
- R4: `ret_pc` always shows entry[(pointer+1) mod 16] combinationally. When `ret_req` is the highest request, the pointer increments by one and no entry changes.
- R5: Requests are served with priority interrupt over call over return. Only the winning request has any effect.
- R6: The pointer wraps modulo 16 in both directions and raises no error.
- R7: The port read data `io_rdata` is combinational. Index 0 to 15 returns that entry. Index 16 returns the pointer in bits 3:0 with the other bits zero. Index 17 to 31 returns zero.
- R8: With `io_we` high and no request active, index 0 to 15 writes `io_wdata` into that entry with bit 13 cleared, and index 16 loads `io_wdata[3:0]` into the pointer. Index 17 to 31 changes nothing.
- R9: A port write made in the same cycle as any of `call_req`, `int_req` or `ret_req` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| call_req | input | 1 | Subroutine call push |
| int_req | input | 1 | Interrupt entry push |
| ret_req | input | 1 | Return pop (all return variants) |
| pc_in | input | 14 | Current program counter |
| int_addr | input | 14 | Resume address of interrupted code |
| ret_pc | output | 14 | Entry above the pointer, toward the program counter |
| io_we | input | 1 | Port write strobe |
| io_idx | input | 5 | Port index (0-15 entries, 16 pointer) |
| io_wdata | input | 14 | Port write data |
| io_rdata | output | 14 | Port read data |

## Verification
The bench builds the block with its default parameters: 14-bit entries and a depth of 16. At this size a run of 20 pushes and a longer run of pops wrap the pointer through both ends within a few dozen cycles. The 5-bit index also covers the unused indices 17 to 31. A pseudo-random phase with frequent request collisions and port writes exercises the priority order and the ignored-write case against a behavioural model.

// File: rtl/ras_pkg.sv
package ras_pkg;
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_PUSH_CALL,
        OP_PUSH_INT,
        OP_POP,
        OP_WR_ENTRY,
        OP_WR_PTR
    } ras_op_e;
endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
    import ras_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int IDX_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_req,
    input  logic              int_req,
    input  logic              ret_req,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] int_addr,
    input  logic              io_we,
    input  logic [IDX_W-1:0]  io_idx,
    input  logic [ADDR_W-1:0] io_wdata,
    output logic [PTR_W-1:0]  ptr,
    output logic [PTR_W-1:0]  ptr_up,
    output logic              ent_we,
    output logic [PTR_W-1:0]  ent_sel,
    output logic [ADDR_W-1:0] ent_data
);
    localparam logic [IDX_W-1:0]  PTR_IDX  = IDX_W'(DEPTH);
    localparam logic [PTR_W-1:0]  PTR_INIT = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0]  PTR_ONE  = PTR_W'(1);
    localparam logic [ADDR_W-1:0] LOW_MASK = {1'b0, {(ADDR_W-1){1'b1}}};

    ras_op_e          op;
    logic [PTR_W-1:0] ptr_d;

    assign ptr_up = ptr + PTR_ONE;

    // pick one operation per cycle
    always_comb begin
        if (int_req)                          op = OP_PUSH_INT;
        else if (call_req)                    op = OP_PUSH_CALL;
        else if (ret_req)                     op = OP_POP;
        else if (io_we && io_idx < PTR_IDX)   op = OP_WR_ENTRY;
        else if (io_we && io_idx == PTR_IDX)  op = OP_WR_PTR;
        else                                  op = OP_IDLE;
    end

    // outputs of the chosen operation
    always_comb begin
        ent_we   = 1'b0;
        ent_sel  = ptr;
        ent_data = '0;
        ptr_d    = ptr;
        unique case (op)
            OP_PUSH_INT: begin
                ent_we   = 1'b1;
                ent_data = int_addr & LOW_MASK;
                ptr_d    = ptr - PTR_ONE;
            end
            OP_PUSH_CALL: begin
                ent_we   = 1'b1;
                ent_data = (pc_in + ADDR_W'(1)) & LOW_MASK;
                ptr_d    = ptr - PTR_ONE;
            end
            OP_POP: begin
                ptr_d = ptr_up;
            end
            OP_WR_ENTRY: begin
                ent_we   = 1'b1;
                ent_sel  = io_idx[PTR_W-1:0];
                ent_data = io_wdata & LOW_MASK;
            end
            OP_WR_PTR: begin
                ptr_d = io_wdata[PTR_W-1:0];
            end
            OP_IDLE: begin
                ptr_d = ptr;
            end
            default: begin
                ptr_d = ptr;
            end
        endcase
    end

    // pointer register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr <= PTR_INIT;
        else        ptr <= ptr_d;
    end

    // R2 R3 R6
    push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req || call_req) |=> ptr == $past(ptr) - PTR_ONE);

    // R4 R6
    pop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !int_req && !call_req) |=> ptr == $past(ptr) + PTR_ONE);

    // R8
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ret_req && !int_req && !call_req && !io_we) |=> $stable(ptr));

    // R9
    port_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_we && (ret_req || int_req || call_req)) |-> (ent_we == (int_req || call_req)) && ent_sel == ptr);
endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int ADDR_W = 14,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_a_sel,
    output logic [ADDR_W-1:0] rd_a_data,
    input  logic [PTR_W-1:0]  rd_b_sel,
    output logic [ADDR_W-1:0] rd_b_data
);
    logic [ADDR_W-1:0] ent_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            ent_q[g] <= '0;
            else if (wr_en && wr_sel == PTR_W'(g)) ent_q[g] <= wr_data;
        end

        // R2 R3 R8
        top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ent_q[g][ADDR_W-1] == 1'b0);

        // R4
        entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_sel == PTR_W'(g)) |=> $stable(ent_q[g]));
    end

    assign rd_a_data = ent_q[rd_a_sel];
    assign rd_b_data = ent_q[rd_b_sel];
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
    import ras_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int IDX_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              call_req,
    input  logic              int_req,
    input  logic              ret_req,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] int_addr,
    output logic [ADDR_W-1:0] ret_pc,
    input  logic              io_we,
    input  logic [IDX_W-1:0]  io_idx,
    input  logic [ADDR_W-1:0] io_wdata,
    output logic [ADDR_W-1:0] io_rdata
);
    localparam logic [IDX_W-1:0] PTR_IDX = IDX_W'(DEPTH);

    logic [PTR_W-1:0]  ptr, ptr_up, ent_sel;
    logic              ent_we;
    logic [ADDR_W-1:0] ent_data, port_ent;

    ras_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .call_req(call_req), .int_req(int_req), .ret_req(ret_req),
        .pc_in(pc_in), .int_addr(int_addr),
        .io_we(io_we), .io_idx(io_idx), .io_wdata(io_wdata),
        .ptr(ptr), .ptr_up(ptr_up),
        .ent_we(ent_we), .ent_sel(ent_sel), .ent_data(ent_data)
    );

    ras_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ent_we), .wr_sel(ent_sel), .wr_data(ent_data),
        .rd_a_sel(io_idx[PTR_W-1:0]), .rd_a_data(port_ent),
        .rd_b_sel(ptr_up), .rd_b_data(ret_pc)
    );

    always_comb begin
        if (io_idx < PTR_IDX)       io_rdata = port_ent;
        else if (io_idx == PTR_IDX) io_rdata = ADDR_W'(ptr);
        else                        io_rdata = '0;
    end

    // R7
    unused_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_idx > PTR_IDX) |-> io_rdata == '0);
endmodule

// File: tb/ret_addr_stack_test.sv
`timescale 1ns/1ps
module ret_addr_stack_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_req = 0, int_req = 0, ret_req = 0, io_we = 0;
    logic [13:0] pc_in = 0, int_addr = 0, io_wdata = 0;
    logic [4:0]  io_idx = 0;
    logic [13:0] ret_pc, io_rdata;

    int vectors = 0, miscompares = 0;
    int m_ent [16];
    int m_ptr = 15;
    int lfsr = 32'h1ACE;

    always #2.5 clk = ~clk;

    ret_addr_stack uut (
        .clk(clk), .rst_n(rst_n),
        .call_req(call_req), .int_req(int_req), .ret_req(ret_req),
        .pc_in(pc_in), .int_addr(int_addr), .ret_pc(ret_pc),
        .io_we(io_we), .io_idx(io_idx), .io_wdata(io_wdata), .io_rdata(io_rdata)
    );

    function automatic int exp_rd(int idx);
        if (idx < 16)  return m_ent[idx];
        if (idx == 16) return m_ptr;
        return 0;
    endfunction

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // drive one cycle, compare outputs, then advance the model at the edge
    task automatic cyc(string req, bit i_r, bit c_r, bit r_r, int pc, int ia,
                       bit we, int idx, int wd);
        @(negedge clk);
        int_req = i_r; call_req = c_r; ret_req = r_r;
        pc_in = 14'(pc); int_addr = 14'(ia);
        io_we = we; io_idx = 5'(idx); io_wdata = 14'(wd);
        #1;
        check(req, int'(ret_pc), m_ent[(m_ptr + 1) & 15]);
        check(req, int'(io_rdata), exp_rd(idx & 31));
        @(posedge clk);
        if (i_r) begin
            m_ent[m_ptr] = ia & 'h1FFF; m_ptr = (m_ptr - 1) & 15;
        end else if (c_r) begin
            m_ent[m_ptr] = (pc + 1) & 'h1FFF; m_ptr = (m_ptr - 1) & 15;
        end else if (r_r) begin
            m_ptr = (m_ptr + 1) & 15;
        end else if (we) begin
            if ((idx & 31) < 16)       m_ent[idx & 15] = wd & 'h1FFF;
            else if ((idx & 31) == 16) m_ptr = wd & 15;
        end
    endtask

    task automatic idle_read(string req, int idx);
        cyc(req, 0, 0, 0, 0, 0, 0, idx, 0);
    endtask

    initial begin
        #100000;
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) m_ent[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        for (int i = 0; i <= 16; i++) idle_read("R1", i);
        // R2 call pushes, incl. +1 wrap and bit 13 clearing
        cyc("R2", 0, 1, 0, 'h3FFF, 0, 0, 16, 0);
        cyc("R2", 0, 1, 0, 'h2ABC, 0, 0, 15, 0);
        cyc("R2", 0, 1, 0, 'h0123, 0, 0, 14, 0);
        idle_read("R2", 13);
        // R3 interrupt push
        cyc("R3", 1, 0, 0, 0, 'h3123, 0, 16, 0);
        idle_read("R3", 12);
        // R4 pops
        for (int i = 0; i < 4; i++) cyc("R4", 0, 0, 1, 0, 0, 0, 16, 0);
        idle_read("R4", 16);
        // R5 collisions
        cyc("R5", 1, 1, 1, 'h0444, 'h0555, 0, 16, 0);
        cyc("R5", 0, 1, 1, 'h0666, 0, 0, 16, 0);
        idle_read("R5", 15);
        idle_read("R5", 14);
        // R6 wrap downward then upward
        for (int i = 0; i < 20; i++) cyc("R6", 0, 1, 0, i * 7, 0, 0, 16, 0);
        for (int i = 0; i < 36; i++) cyc("R6", 0, 0, 1, 0, 0, 0, 16, 0);
        // R7 unused indices read zero
        for (int i = 17; i < 32; i++) idle_read("R7", i);
        // R8 port writes
        cyc("R8", 0, 0, 0, 0, 0, 1, 5, 'h3FFF);
        idle_read("R8", 5);
        cyc("R8", 0, 0, 0, 0, 0, 1, 16, 'h0009);
        idle_read("R8", 16);
        cyc("R8", 0, 0, 0, 0, 0, 1, 20, 'h1234);
        for (int i = 0; i <= 16; i++) idle_read("R8", i);
        // R9 port writes blocked by requests
        cyc("R9", 0, 0, 1, 0, 0, 1, 16, 'h0002);
        idle_read("R9", 16);
        cyc("R9", 0, 1, 0, 'h0100, 0, 1, 3, 'h0777);
        idle_read("R9", 3);
        cyc("R9", 1, 0, 0, 0, 'h0200, 1, 16, 'h0001);
        idle_read("R9", 16);
        // R5 mixed pseudo-random traffic
        for (int i = 0; i < 300; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
            cyc("R5", (lfsr & 7) == 0, (lfsr & 6) == 2, (lfsr & 12) == 4,
                lfsr >> 3, lfsr >> 5, (lfsr & 48) == 16, (lfsr >> 7) % 18,
                lfsr >> 9);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule